// File: doc/BRIEF.md
# Mains Zero-Crossing Predictor

This block turns a 1-bit digitised mains-sense signal into a one-cycle crossing flag with a timestamp. The raw input first passes through a two-stage synchroniser and a deglitch filter. The filter accepts a new level only after that level has held for a programmable number of clock cycles. A conditioning stage can then invert the signal. It can also treat both its high and its low phases as pulses, which halves the conditioned period.

A tracking loop takes the centre of each conditioned pulse as a crossing. It measures the period between successive centres and keeps only periods inside a window that spans 50 Hz and 60 Hz mains with ±10 % deviation. It then raises the flag at the time it predicts for the next crossing: the last centre plus the period estimate. The loop can report every crossing, or only rising or only falling ones.

A free-running cycle counter supplies the timestamps. Two external peak events can each copy the latest crossing time into a capture register, each under its own enable. All modes are set through a single write port whose value reads back in parallel.

Top module: `zc_predictor`

## Requirements
- R1: After synchronous reset, `zc_flag`, `xing_time`, `peak_stamp` and `cond_level` are 0 and `cfg_rdata` reads 0x0100 (hold count 8, every other field 0).
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the configuration, which `cfg_rdata` shows from the next cycle. The field layout is: bit 0 one_kind, bit 1 pick_desc, bit 2 invert, bit 3 halve, bit 4 filt_off, bits 11:5 hold, bit 12 cap_a_en, bit 13 cap_b_en. Without `cfg_we` the configuration holds.
- R3: With filt_off = 0, a new input level reaches `cond_level` only after it has held for `hold` consecutive cycles. A level held for `hold` cycles appears for exactly `hold` cycles, and one held for `hold`-1 cycles never appears.
- R4: With filt_off = 1, the synchronised input reaches `cond_level` with no hold requirement, so a single-cycle input pulse shows for one cycle.
- R5: `cond_level` equals the filtered input XOR invert, so with invert = 1 a low input reads as 1.
- R6: A crossing is the centre of a conditioned high pulse. After two centres spaced by an accepted period, `zc_flag` pulses for one cycle at each predicted crossing, a fixed small latency after the centre of the raw pulse.
- R7: `xing_time` takes the value of the free-running cycle count at each flag. Successive flags on a regular pulse train differ in `xing_time` by exactly the pulse period.
- R8: A measured period outside [0.9·P60_CYC, 1.1·P50_CYC] is rejected and the previous estimate is kept. The next crossing is then predicted as the rejected centre plus the old period.
- R9: With halve = 1, the centres of both high and low phases are crossings, so flags come every half raw period.
- R10: With one_kind = 1, only crossings of the selected kind are flagged: centres of high phases when pick_desc = 0, centres of low phases when pick_desc = 1. A parity that is realigned at every measured centre decides the kind.
- R11: `peak_stamp` loads the current `xing_time` in the cycle after `peak_a_evt` with cap_a_en = 1 or `peak_b_evt` with cap_b_en = 1. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_in | input | 1 | Raw digitised mains-sense signal |
| peak_a_evt | input | 1 | First peak event |
| peak_b_evt | input | 1 | Second peak event |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 14 | Configuration write value |
| zc_flag | output | 1 | One-cycle predicted crossing flag |
| xing_time | output | 32 | Cycle count at the last flagged crossing |
| peak_stamp | output | 32 | Crossing time captured at a peak event |
| cond_level | output | 1 | Filtered and inverted input level |
| cfg_rdata | output | 14 | Current configuration |

## Verification
A wrong deglitch count shows on `cond_level` within one pulse, as a high-time different from the hold count. A bad midpoint or period estimate moves the flags. From the third pulse on, the flags then either leave the centre of their pulse or step away from the pulse period in `xing_time`. An accepted out-of-window period or a misaligned edge parity shows at the very next predicted crossing: the spacing becomes wrong, or a flag falls in a phase of the wrong level.

// File: rtl/zcp_pkg.sv
package zcp_pkg;

    localparam int HOLD_W = 7;

    // Configuration word; bit order is the write-port layout.
    typedef struct packed {
        logic              cap_b_en;
        logic              cap_a_en;
        logic [HOLD_W-1:0] hold;
        logic              filt_off;
        logic              halve;
        logic              invert;
        logic              pick_desc;
        logic              one_kind;
    } zc_cfg_t;

    localparam int CFG_W = $bits(zc_cfg_t);

    localparam zc_cfg_t CFG_RESET = '{
        cap_b_en: 1'b0, cap_a_en: 1'b0, hold: 7'd8, filt_off: 1'b0,
        halve: 1'b0, invert: 1'b0, pick_desc: 1'b0, one_kind: 1'b0
    };

    // Segment events from the conditioning stage.
    typedef struct packed {
        logic start;     // a pulse begins
        logic stop;      // a pulse ends
        logic low_seg;   // the segment just ended was a low phase
    } seg_evt_t;

    function automatic logic hold_reached(input logic [HOLD_W-1:0] cnt,
                                          input logic [HOLD_W-1:0] hold);
        return ({1'b0, cnt} + {{HOLD_W{1'b0}}, 1'b1}) >= {1'b0, hold};
    endfunction

endpackage

// File: rtl/zcp_deglitch.sv
module zcp_deglitch
    import zcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              raw,
    input  logic              bypass,
    input  logic [HOLD_W-1:0] hold,
    output logic              level
);
    logic s1, s2;
    logic [HOLD_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            level <= 1'b0;
            cnt   <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (bypass) begin
                level <= s2;
                cnt   <= '0;
            end else if (s2 == level) begin
                cnt <= '0;
            end else if (hold_reached(cnt, hold)) begin
                level <= s2;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_STILL_INPUT: assert property (@(posedge clk) disable iff (rst)
        (!bypass && s2 == level) |=> $stable(level)); // R3

endmodule

// File: rtl/zcp_condition.sv
module zcp_condition
    import zcp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     level,
    input  logic     invert,
    input  logic     halve,
    output logic     cond,
    output seg_evt_t evt
);
    logic c_q, rise, fall;

    assign cond = level ^ invert;
    assign rise = cond & ~c_q;
    assign fall = ~cond & c_q;

    always_ff @(posedge clk) begin
        if (rst) c_q <= 1'b0;
        else     c_q <= cond;
    end

    always_comb begin
        evt.start   = halve ? (rise | fall) : rise;
        evt.stop    = halve ? (rise | fall) : fall;
        evt.low_seg = ~c_q;
    end

endmodule

// File: rtl/zcp_tracker.sv
module zcp_tracker
    import zcp_pkg::*;
#(
    parameter int TIME_W  = 32,
    parameter int PER_MIN = 900,
    parameter int PER_MAX = 1320
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] now,
    input  seg_evt_t          evt,
    input  logic              halve,
    input  logic              one_kind,
    input  logic              pick_desc,
    output logic              flag,
    output logic [TIME_W-1:0] flag_time
);
    localparam logic [TIME_W-1:0] LO = TIME_W'(PER_MIN);
    localparam logic [TIME_W-1:0] HI = TIME_W'(PER_MAX);

    logic [TIME_W-1:0] st, last_mid, per_est, pred, mid, per;
    logic st_v, mid_v, locked, nk, par;
    logic kind_m, good, hit, report;

    always_comb begin
        mid    = st + ((now - st) >> 1);
        per    = mid - last_mid;
        kind_m = halve ? evt.low_seg : par;
        good   = mid_v && (per >= LO) && (per <= HI);
        hit    = locked && (now == pred);
        report = hit && (!one_kind || (nk == pick_desc));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0; last_mid <= '0; per_est <= '0; pred <= '0;
            st_v <= 1'b0; mid_v <= 1'b0; locked <= 1'b0;
            nk <= 1'b0; par <= 1'b0;
            flag <= 1'b0; flag_time <= '0;
        end else begin
            flag <= report;
            if (report) flag_time <= now;

            if (evt.stop && st_v) begin
                last_mid <= mid;
                mid_v    <= 1'b1;
                par      <= ~par;
                if (good) begin
                    per_est <= per;
                    locked  <= 1'b1;
                    pred    <= mid + per;
                    nk      <= ~kind_m;
                end else if (locked) begin
                    pred <= mid + per_est;
                    nk   <= ~kind_m;
                end
            end else if (hit) begin
                pred <= pred + per_est;
                nk   <= ~nk;
            end

            if (evt.start) begin
                st   <= now;
                st_v <= 1'b1;
            end
        end
    end

    AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        flag |=> !flag); // R6
    AST_FLAG_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        flag |-> locked); // R6
    AST_EST_WINDOW: assert property (@(posedge clk) disable iff (rst)
        locked |-> (per_est >= LO && per_est <= HI)); // R8

endmodule

// File: rtl/zc_predictor.sv
module zc_predictor
    import zcp_pkg::*;
#(
    parameter int TIME_W  = 32,
    parameter int P50_CYC = 1200,
    parameter int P60_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              zc_in,
    input  logic              peak_a_evt,
    input  logic              peak_b_evt,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              zc_flag,
    output logic [TIME_W-1:0] xing_time,
    output logic [TIME_W-1:0] peak_stamp,
    output logic              cond_level,
    output logic [CFG_W-1:0]  cfg_rdata
);
    localparam int PER_MIN = (P60_CYC * 9) / 10;
    localparam int PER_MAX = (P50_CYC * 11) / 10;

    zc_cfg_t           cfg_q;
    logic [TIME_W-1:0] now;
    logic              level;
    seg_evt_t          evt;
    logic              cap;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_RESET;
        else if (cfg_we) cfg_q <= zc_cfg_t'(cfg_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end

    assign cap = (peak_a_evt && cfg_q.cap_a_en) || (peak_b_evt && cfg_q.cap_b_en);

    always_ff @(posedge clk) begin
        if (rst)      peak_stamp <= '0;
        else if (cap) peak_stamp <= xing_time;
    end

    assign cfg_rdata = cfg_q;

    zcp_deglitch u_deglitch (
        .clk(clk), .rst(rst), .raw(zc_in), .bypass(cfg_q.filt_off),
        .hold(cfg_q.hold), .level(level)
    );

    zcp_condition u_condition (
        .clk(clk), .rst(rst), .level(level), .invert(cfg_q.invert),
        .halve(cfg_q.halve), .cond(cond_level), .evt(evt)
    );

    zcp_tracker #(.TIME_W(TIME_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)) u_tracker (
        .clk(clk), .rst(rst), .now(now), .evt(evt), .halve(cfg_q.halve),
        .one_kind(cfg_q.one_kind), .pick_desc(cfg_q.pick_desc),
        .flag(zc_flag), .flag_time(xing_time)
    );

    AST_PEAK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(peak_stamp)); // R11
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_rdata)); // R2

endmodule

// File: tb/zc_predictor_test.sv
module zc_predictor_test;
    import zcp_pkg::*;

    logic clk = 1'b0, rst = 1'b1, zc_in = 1'b0;
    logic peak_a_evt = 1'b0, peak_b_evt = 1'b0, cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic zc_flag, cond_level;
    logic [31:0] xing_time, peak_stamp;
    logic [CFG_W-1:0] cfg_rdata;

    int checks = 0, errors = 0, cyc = 0;
    int gap[16];
    int ngap, nrec, t0;
    int rec_cyc[32];
    longint rec_ts[32];
    bit rec_lvl[32];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    zc_predictor uut (
        .clk(clk), .rst(rst), .zc_in(zc_in), .peak_a_evt(peak_a_evt),
        .peak_b_evt(peak_b_evt), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .zc_flag(zc_flag), .xing_time(xing_time), .peak_stamp(peak_stamp),
        .cond_level(cond_level), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; zc_in = 1'b0; cfg_we = 1'b0; peak_a_evt = 1'b0; peak_b_evt = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [CFG_W-1:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic count_high(input int w, input int span, output int n);
        n = 0;
        for (int c = 0; c < span; c++) begin
            @(negedge clk);
            if (cond_level) n++;
            zc_in = (c < w);
        end
        zc_in = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic play(input int hw);
        bit busy;
        busy = 1'b1;
        nrec = 0;
        fork
            begin
                @(negedge clk);
                t0 = cyc;
                for (int i = 0; i < ngap; i++) begin
                    zc_in = 1'b1;
                    repeat (hw) @(negedge clk);
                    zc_in = 1'b0;
                    repeat (gap[i] - hw) @(negedge clk);
                end
                busy = 1'b0;
            end
            begin
                while (busy) begin
                    @(posedge clk);
                    #2;
                    if (busy && zc_flag && nrec < 32) begin
                        rec_cyc[nrec] = cyc;
                        rec_ts[nrec]  = longint'(xing_time);
                        rec_lvl[nrec] = zc_in;
                        nrec++;
                    end
                end
            end
        join
    endtask

    task automatic t_reset();
        do_reset();
        chk(zc_flag == 1'b0, "R1 flag", zc_flag, 0);
        chk(xing_time == 0, "R1 xing_time", xing_time, 0);
        chk(peak_stamp == 0, "R1 peak_stamp", peak_stamp, 0);
        chk(cond_level == 1'b0, "R1 cond_level", cond_level, 0);
        chk(cfg_rdata == 14'h0100, "R1 cfg_rdata", cfg_rdata, 14'h0100);
    endtask

    task automatic t_config();
        write_cfg(14'h3FFF);
        chk(cfg_rdata == 14'h3FFF, "R2 readback all ones", cfg_rdata, 14'h3FFF);
        write_cfg(14'h1555);
        repeat (3) @(negedge clk);
        chk(cfg_rdata == 14'h1555, "R2 readback holds", cfg_rdata, 14'h1555);
        write_cfg(14'h0100);
    endtask

    task automatic t_deglitch();
        int n;
        do_reset();
        count_high(7, 60, n);
        chk(n == 0, "R3 hold-1 pulse rejected", n, 0);
        count_high(8, 60, n);
        chk(n == 8, "R3 hold pulse accepted", n, 8);
        write_cfg(14'h0280);
        count_high(19, 80, n);
        chk(n == 0, "R3 hold=20 short pulse", n, 0);
        count_high(20, 80, n);
        chk(n == 20, "R3 hold=20 exact pulse", n, 20);
    endtask

    task automatic t_bypass();
        int n;
        do_reset();
        count_high(1, 30, n);
        chk(n == 0, "R4 filtered single cycle", n, 0);
        write_cfg(14'h0110);
        count_high(1, 30, n);
        chk(n == 1, "R4 bypass single cycle", n, 1);
    endtask

    task automatic t_invert();
        do_reset();
        write_cfg(14'h0114);
        zc_in = 1'b0;
        repeat (6) @(negedge clk);
        chk(cond_level == 1'b1, "R5 low input inverted", cond_level, 1);
        zc_in = 1'b1;
        repeat (6) @(negedge clk);
        chk(cond_level == 1'b0, "R5 high input inverted", cond_level, 0);
        zc_in = 1'b0;
    endtask

    task automatic t_track_and_peak();
        longint exp;
        do_reset();
        ngap = 6;
        for (int i = 0; i < 6; i++) gap[i] = 1000;
        play(300);
        chk(nrec == 4, "R6 flag count", nrec, 4);
        for (int i = 0; i < nrec && i < 4; i++) begin
            int off;
            off = (rec_cyc[i] - t0) % 1000;
            chk(off >= 150 && off <= 185, "R6 flag at pulse centre", off, 150);
            chk(rec_lvl[i] == 1'b1, "R6 flag inside high pulse", rec_lvl[i], 1);
            if (i > 0) begin
                chk(rec_ts[i] - rec_ts[i-1] == 1000, "R7 timestamp spacing",
                    rec_ts[i] - rec_ts[i-1], 1000);
                chk(rec_ts[i] - rec_cyc[i] == rec_ts[0] - rec_cyc[0], "R7 stamp tracks count",
                    rec_ts[i] - rec_cyc[i], rec_ts[0] - rec_cyc[0]);
            end
        end
        // R11: captures gated by the enables
        @(negedge clk); peak_a_evt = 1'b1; peak_b_evt = 1'b1;
        @(negedge clk); peak_a_evt = 1'b0; peak_b_evt = 1'b0;
        chk(peak_stamp == 0, "R11 disabled peaks ignored", peak_stamp, 0);
        write_cfg(14'h2100);
        @(negedge clk); peak_a_evt = 1'b1;
        @(negedge clk); peak_a_evt = 1'b0;
        chk(peak_stamp == 0, "R11 peak a ignored when only b enabled", peak_stamp, 0);
        @(negedge clk); peak_b_evt = 1'b1; exp = longint'(xing_time);
        @(negedge clk); peak_b_evt = 1'b0;
        chk(exp != 0 && longint'(peak_stamp) == exp, "R11 peak b capture", peak_stamp, exp);
    endtask

    task automatic t_reject();
        do_reset();
        ngap = 7;
        for (int i = 0; i < 7; i++) gap[i] = 1000;
        gap[3] = 700;
        play(300);
        chk(nrec == 4, "R8 flag count", nrec, 4);
        if (nrec >= 4) begin
            chk(rec_ts[2] - rec_ts[1] == 1700, "R8 out-of-window period rejected",
                rec_ts[2] - rec_ts[1], 1700);
            chk(rec_ts[3] - rec_ts[2] == 1000, "R8 estimate kept",
                rec_ts[3] - rec_ts[2], 1000);
        end
    endtask

    task automatic t_halve(input logic [CFG_W-1:0] cfg, input int exp_n,
                           input int exp_gap, input int lvl_mode, input string req);
        do_reset();
        write_cfg(cfg);
        ngap = 4;
        for (int i = 0; i < 4; i++) gap[i] = 2000;
        play(800);
        chk(nrec == exp_n, {req, " flag count"}, nrec, exp_n);
        for (int i = 0; i < nrec && i < exp_n; i++) begin
            bit el;
            // lvl_mode 0: alternate starting high, 1: all high, 2: all low
            el = (lvl_mode == 0) ? ((i % 2) == 0) : (lvl_mode == 1);
            chk(rec_lvl[i] == el, {req, " flag phase level"}, rec_lvl[i], el);
            if (i > 0)
                chk(rec_ts[i] - rec_ts[i-1] == exp_gap, {req, " flag spacing"},
                    rec_ts[i] - rec_ts[i-1], exp_gap);
        end
    endtask

    initial begin
        #(8 * 180000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_config();
        t_deglitch();
        t_bypass();
        t_invert();
        t_track_and_peak();
        t_reject();
        t_halve(14'h0108, 6, 1000, 0, "R9 halve both kinds");
        t_halve(14'h0109, 3, 2000, 1, "R10 rising only");
        t_halve(14'h010B, 3, 2000, 2, "R10 falling only");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule